// File: doc/BRIEF.md
# Paper-Tape Binary Loader

This block turns a stream of 8-bit tape characters into 12-bit words and stores them in a word-addressed memory. The memory holds up to eight fields of 4096 words, so a store address is 15 bits wide. Each word is made from two successive characters, and only the low six bits of each character are used.

The `fmt_sel` input picks the tape format. With `fmt_sel = 0` the block reads checksummed block tapes. These tapes carry control characters:
- rubout characters, which are skipped;
- field-select characters, which take effect one word late;
- origin words, which set the load address.

A running checksum is kept and is compared with the final word when the trailer arrives. With `fmt_sel = 1` the block reads simple tapes of alternating address and data words. These tapes have no checksum and always load into field 0.

A host pulses `start`, presents characters on a valid/ready handshake, and watches four sticky status outputs. `stream_end` tells the block that no more characters will come.

The controller is a state machine with five states:
- `S_LEAD` waits out the leader.
- `S_LOWCH` expects the second character of a pair.
- `S_HIGHCH` expects the first character of the next pair, or the trailer.
- `S_END` means the load finished at a trailer.
- `S_HALT` means the load stopped on an address error or an early end of stream.

The transitions are:
- LEAD→LOWCH on the first character that is not leader.
- LOWCH→HIGHCH on any accepted pair character.
- HIGHCH→LOWCH when a new pair starts.
- HIGHCH→END on the trailer.
- HIGHCH→HALT on an out-of-range store.
- LEAD/LOWCH/HIGHCH→HALT when `stream_end` arrives.
- Any state→LEAD on `start`.

Top module: `tape_loader`

## Requirements
- R1: A pair is built as `{first[5:0], second[5:0]}`. In block mode a data pair is written to `{field, origin}` with `mem_we` high for one cycle, right after the first character of the next pair is accepted.
- R2: A pair whose first character has bit 6 (octal 0100) set is an origin. Its 12 bits load the origin register and no memory write happens.
- R3: After each block-mode data write the origin advances by one, and 07777 wraps to 0.
- R4: In block mode, the characters 0 and 0200 are skipped while the block waits for the first pair, and no write happens during leader.
- R5: In block mode, the character 0377 is thrown away together with the single character that follows it. Neither one enters a pair or the checksum.
- R6: In block mode, a character above 0200 other than 0377 sets a pending field from its bits 5:3. The pending field becomes active when the pair in progress completes, so it first applies to the next pair.
- R7: In block mode, a 0200 in the first-character position is the trailer. The pair before it is the checksum. `done` rises, and `csum_err` also rises if the 12-bit sum of the raw characters of all earlier pairs differs from that checksum.
- R8: In block mode, a data write whose address is at or above `mem_size` sets `addr_err`. That write is not issued, and loading stops (`S_HALT`).
- R9: In address/data mode (`fmt_sel = 1`), the leader lasts until a nonzero character below 0200 arrives. An address pair sets the address, and each data pair is written to `{0, address}` with no increment. A first character of 0200 or more sets `done`, and no checksum is checked.
- R10: If `stream_end` is asserted before the load has ended or halted, `fmt_err` rises. After a clean end, `stream_end` has no effect.
- R11: Reset and `start` clear all status outputs, the origin, both field registers and the sum. The status outputs stay set until one of these is applied.
- R12: `byte_ready` is low in every cycle in which `mem_we` is high, and two writes are never issued in consecutive cycles.
- R13: Once the load has ended or halted, further characters are accepted but produce no writes and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Synchronous pulse that clears the loader and begins a new load |
| fmt_sel | input | 1 | Tape format: 0 = checksummed block, 1 = address/data |
| mem_size | input | 16 | Number of words of memory present |
| byte_valid | input | 1 | A tape character is offered |
| byte_data | input | 8 | Tape character |
| byte_ready | output | 1 | The character is accepted on this cycle's edge |
| stream_end | input | 1 | No more characters will come |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 15 | Write address: field in bits 14:12, word in bits 11:0 |
| mem_wdata | output | 12 | Write data |
| done | output | 1 | Load reached its end marker (sticky) |
| csum_err | output | 1 | Checksum mismatch at the trailer (sticky) |
| addr_err | output | 1 | Store beyond the configured memory (sticky) |
| fmt_err | output | 1 | Stream ended before the trailer (sticky) |

## Verification
The assertions assume that `fmt_sel` and `mem_size` are held steady for the whole of a load, because the range check on issued writes compares against the present `mem_size`. They also assume that `start` is pulsed only while no write is pending. The stimulus changes `fmt_sel` and `mem_size` only in the idle gap before a `start` pulse. It offers each character only after it sees `byte_ready` high on a falling edge, and it raises `stream_end` only while no character is being offered.

// File: rtl/tape_pkg.sv
package tape_pkg;
    typedef enum logic [2:0] {
        S_LEAD   = 3'd0,
        S_LOWCH  = 3'd1,
        S_HIGHCH = 3'd2,
        S_END    = 3'd3,
        S_HALT   = 3'd4
    } ld_state_e;

    localparam int TP_CHAR_W  = 8;
    localparam int TP_WORD_W  = 12;
    localparam int TP_FIELD_W = 3;
    localparam int TP_FLD_LSB = 3;
endpackage

// File: rtl/tape_char_class.sv
module tape_char_class #(
    parameter int CHAR_W  = 8,
    parameter int FIELD_W = 3,
    parameter int FLD_LSB = 3
) (
    input  logic [CHAR_W-1:0]  ch,
    input  logic               blk,
    output logic               is_rub,
    output logic               is_fld,
    output logic               is_lead,
    output logic               is_stop,
    output logic [FIELD_W-1:0] fld_num
);
    localparam logic [CHAR_W-1:0] TOP  = {1'b1, {(CHAR_W-1){1'b0}}};
    localparam logic [CHAR_W-1:0] ONES = '1;

    always_comb begin
        fld_num = ch[FLD_LSB +: FIELD_W];
        if (blk) begin
            is_rub  = (ch == ONES);
            is_fld  = (ch > TOP) && (ch != ONES);
            is_lead = (ch == '0) || (ch == TOP);
            is_stop = (ch == TOP);
        end else begin
            is_rub  = 1'b0;
            is_fld  = 1'b0;
            is_lead = (ch == '0) || (ch >= TOP);
            is_stop = (ch >= TOP);
        end
    end

    // R5/R6: a character falls into at most one skip class
    always_comb begin
        a_r5_class_exclusive: assert ($onehot0({is_rub, is_fld, is_lead}));
    end
endmodule

// File: rtl/tape_sum_acc.sv
module tape_sum_acc #(
    parameter int WORD_W = 12,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [CHAR_W-1:0] a,
    input  logic [CHAR_W-1:0] b,
    output logic [WORD_W-1:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sum <= '0;
        else if (clr)
            sum <= '0;
        else if (add)
            sum <= sum + WORD_W'(a) + WORD_W'(b);
    end
endmodule

// File: rtl/tape_addr_gen.sv
module tape_addr_gen #(
    parameter int WORD_W  = 12,
    parameter int FIELD_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               org_load,
    input  logic [WORD_W-1:0]  org_val,
    input  logic               org_inc,
    input  logic               fld_set,
    input  logic [FIELD_W-1:0] fld_val,
    input  logic               fld_commit,
    output logic [WORD_W-1:0]  origin,
    output logic [FIELD_W-1:0] field
);
    logic [FIELD_W-1:0] fld_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            origin   <= '0;
            field    <= '0;
            fld_pend <= '0;
        end else if (clr) begin
            origin   <= '0;
            field    <= '0;
            fld_pend <= '0;
        end else begin
            if (org_load)
                origin <= org_val;
            else if (org_inc)
                origin <= origin + 1'b1;
            if (fld_set)
                fld_pend <= fld_val;
            if (fld_commit)
                field <= fld_pend;
        end
    end
endmodule

// File: rtl/tape_loader.sv
module tape_loader
    import tape_pkg::*;
#(
    parameter int WORD_W  = TP_WORD_W,
    parameter int FIELD_W = TP_FIELD_W,
    parameter int CHAR_W  = TP_CHAR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       fmt_sel,
    input  logic [FIELD_W+WORD_W:0]    mem_size,
    input  logic                       byte_valid,
    input  logic [CHAR_W-1:0]          byte_data,
    output logic                       byte_ready,
    input  logic                       stream_end,
    output logic                       mem_we,
    output logic [FIELD_W+WORD_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]          mem_wdata,
    output logic                       done,
    output logic                       csum_err,
    output logic                       addr_err,
    output logic                       fmt_err
);
    localparam int ADDR_W  = FIELD_W + WORD_W;
    localparam int FRAME_W = WORD_W / 2;

    ld_state_e state_q, state_d;

    logic              blk, accept, running;
    logic              cls_rub, cls_fld, cls_lead, cls_stop;
    logic [FIELD_W-1:0] fld_num;
    logic [CHAR_W-1:0] hi_q, lo_q;
    logic              skip_q;
    logic [WORD_W-1:0] word_blk, word_ad, org_val, sum, origin;
    logic [FIELD_W-1:0] field;
    logic [ADDR_W-1:0] blk_addr;
    logic              hi_org, oob;
    logic take_hi, take_lo, set_skip, clr_skip, fld_set, fld_commit;
    logic sum_add, org_load, org_inc, wr_blk, wr_ad;
    logic set_done, set_csum, set_addr, set_fmt;

    assign blk        = !fmt_sel;
    assign byte_ready = !mem_we;
    assign accept     = byte_valid && byte_ready;
    assign running    = (state_q == S_LEAD) || (state_q == S_LOWCH) || (state_q == S_HIGHCH);
    assign word_blk   = {hi_q[FRAME_W-1:0], lo_q[FRAME_W-1:0]};
    assign word_ad    = {hi_q[FRAME_W-1:0], byte_data[FRAME_W-1:0]};
    assign hi_org     = hi_q[FRAME_W];
    assign blk_addr   = {field, origin};
    assign oob        = ({1'b0, blk_addr} >= mem_size);

    tape_char_class #(.CHAR_W(CHAR_W), .FIELD_W(FIELD_W), .FLD_LSB(TP_FLD_LSB)) u_class (
        .ch(byte_data), .blk(blk), .is_rub(cls_rub), .is_fld(cls_fld),
        .is_lead(cls_lead), .is_stop(cls_stop), .fld_num(fld_num)
    );

    tape_sum_acc #(.WORD_W(WORD_W), .CHAR_W(CHAR_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .clr(start), .add(sum_add),
        .a(hi_q), .b(lo_q), .sum(sum)
    );

    tape_addr_gen #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .clr(start),
        .org_load(org_load), .org_val(org_val), .org_inc(org_inc),
        .fld_set(fld_set), .fld_val(fld_num), .fld_commit(fld_commit),
        .origin(origin), .field(field)
    );

    // next-state and control strobes
    always_comb begin
        state_d    = state_q;
        take_hi    = 1'b0;  take_lo  = 1'b0;
        set_skip   = 1'b0;  clr_skip = 1'b0;
        fld_set    = 1'b0;  fld_commit = 1'b0;
        sum_add    = 1'b0;  org_load = 1'b0;  org_inc = 1'b0;
        wr_blk     = 1'b0;  wr_ad    = 1'b0;
        set_done   = 1'b0;  set_csum = 1'b0;
        set_addr   = 1'b0;  set_fmt  = 1'b0;
        org_val    = word_blk;
        if (stream_end && running) begin
            set_fmt = 1'b1;
            state_d = S_HALT;
        end else if (accept && running) begin
            if (blk && skip_q) begin
                clr_skip = 1'b1;
            end else if (blk && cls_rub) begin
                set_skip = 1'b1;
            end else if (blk && cls_fld) begin
                fld_set = 1'b1;
            end else begin
                unique case (state_q)
                    S_LEAD: begin
                        if (!cls_lead) begin
                            take_hi = 1'b1;
                            state_d = S_LOWCH;
                        end
                    end
                    S_LOWCH: begin
                        take_lo = 1'b1;
                        state_d = S_HIGHCH;
                        if (!blk) begin
                            if (hi_org) begin
                                org_load = 1'b1;
                                org_val  = word_ad;
                            end else begin
                                wr_ad = 1'b1;
                            end
                        end
                    end
                    S_HIGHCH: begin
                        if (cls_stop) begin
                            set_done = 1'b1;
                            state_d  = S_END;
                            if (blk && (sum != word_blk))
                                set_csum = 1'b1;
                        end else if (!blk) begin
                            take_hi = 1'b1;
                            state_d = S_LOWCH;
                        end else begin
                            sum_add    = 1'b1;
                            fld_commit = 1'b1;
                            take_hi    = 1'b1;
                            state_d    = S_LOWCH;
                            if (hi_org) begin
                                org_load = 1'b1;
                            end else if (oob) begin
                                set_addr = 1'b1;
                                state_d  = S_HALT;
                            end else begin
                                wr_blk  = 1'b1;
                                org_inc = 1'b1;
                            end
                        end
                    end
                    S_END, S_HALT: ;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_LEAD;
        else if (start)
            state_q <= S_LEAD;
        else
            state_q <= state_d;
    end

    // outputs and character registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0; lo_q <= '0; skip_q <= 1'b0;
            mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
            done <= 1'b0; csum_err <= 1'b0; addr_err <= 1'b0; fmt_err <= 1'b0;
        end else if (start) begin
            hi_q <= '0; lo_q <= '0; skip_q <= 1'b0;
            mem_we <= 1'b0;
            done <= 1'b0; csum_err <= 1'b0; addr_err <= 1'b0; fmt_err <= 1'b0;
        end else begin
            mem_we <= wr_blk || wr_ad;
            if (wr_blk) begin
                mem_addr  <= blk_addr;
                mem_wdata <= word_blk;
            end else if (wr_ad) begin
                mem_addr  <= {{FIELD_W{1'b0}}, origin};
                mem_wdata <= word_ad;
            end
            if (take_hi)  hi_q   <= byte_data;
            if (take_lo)  lo_q   <= byte_data;
            if (set_skip) skip_q <= 1'b1;
            if (clr_skip) skip_q <= 1'b0;
            if (set_done) done     <= 1'b1;
            if (set_csum) csum_err <= 1'b1;
            if (set_addr) addr_err <= 1'b1;
            if (set_fmt)  fmt_err  <= 1'b1;
        end
    end

    a_r12_write_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
    a_r8_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !fmt_sel) |-> ({1'b0, mem_addr} < mem_size));
    a_r9_field_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && fmt_sel) |-> (mem_addr[ADDR_W-1:WORD_W] == '0));
    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr_err || fmt_err || csum_err) && !start) |=> (addr_err || fmt_err || csum_err));
    a_r13_no_write_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (done || addr_err || fmt_err) |-> !mem_we);
    a_r7_csum_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
        csum_err |-> done);
endmodule

// File: tb/tb_tape_loader.sv
`timescale 1ns/1ps
module tb_tape_loader;
    logic        clk = 1'b0;
    logic        rst_n, start, fmt_sel, byte_valid, stream_end;
    logic [15:0] mem_size;
    logic [7:0]  byte_data;
    logic        byte_ready, mem_we, done, csum_err, addr_err, fmt_err;
    logic [14:0] mem_addr;
    logic [11:0] mem_wdata;

    always #2.5 clk = ~clk;

    tape_loader dut (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt_sel(fmt_sel),
        .mem_size(mem_size), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ready(byte_ready), .stream_end(stream_end), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done),
        .csum_err(csum_err), .addr_err(addr_err), .fmt_err(fmt_err)
    );

    int nchk = 0, nfail = 0, wr_cnt = 0, viol = 0;
    logic [14:0] wr_addr [0:63];
    logic [11:0] wr_data [0:63];
    logic [11:0] tsum;
    logic        prev_we = 1'b0;

    // {field, origin, data}
    localparam logic [26:0] VEC [0:7] = '{
        {3'o0, 12'o0200, 12'o1234}, {3'o1, 12'o0000, 12'o7777},
        {3'o7, 12'o7777, 12'o0000}, {3'o2, 12'o4000, 12'o5252},
        {3'o3, 12'o1357, 12'o2525}, {3'o5, 12'o0077, 12'o0100},
        {3'o6, 12'o3210, 12'o4567}, {3'o4, 12'o6543, 12'o0001}
    };

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                wr_addr[wr_cnt[5:0]] = mem_addr;
                wr_data[wr_cnt[5:0]] = mem_wdata;
                wr_cnt++;
                if (byte_ready) viol++;
                if (prev_we) viol++;
            end
            prev_we = mem_we;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0o expected %0o", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] c);
        byte_valid = 1'b1;
        byte_data  = c;
        while (!byte_ready) @(negedge clk);
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic send_sum(input logic [7:0] c);
        send(c);
        tsum = tsum + 12'(c);
    endtask

    task automatic send_pair(input logic org, input logic [11:0] w);
        send_sum({1'b0, org, w[11:6]});
        send_sum({2'b00, w[5:0]});
    endtask

    task automatic finish_load(input logic [11:0] ck);
        send({2'b00, ck[11:6]});
        send({2'b00, ck[5:0]});
        send(8'o200);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wr_cnt = 0;
        tsum = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R12 watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; fmt_sel = 1'b0; byte_valid = 1'b0;
        byte_data = '0; stream_end = 1'b0; mem_size = 16'd32768; tsum = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset done", done, 0);
        chk("R11 reset errors", {csum_err, addr_err, fmt_err}, 0);
        chk("R12 reset ready", byte_ready, 1);
        chk("R1 reset write strobe", mem_we, 0);

        // table: field select in leader, origin, one data word, checksum
        for (int i = 0; i < 8; i++) begin
            logic [2:0]  f;
            logic [11:0] o, d;
            {f, o, d} = VEC[i];
            pulse_start();
            send(8'o0); send(8'o200);
            send(8'o300 | {2'b00, f, 3'b000});
            send(8'o200);
            send_pair(1'b1, o);
            send_pair(1'b0, d);
            finish_load(tsum);
            chk("R1/R6 table write count", wr_cnt, 1);
            chk("R1/R6 table address", wr_addr[0], {f, o});
            chk("R1 table data", wr_data[0], d);
            chk("R7 table done", done, 1);
            chk("R7 table checksum ok", csum_err, 0);
        end

        // R3 origin wrap, R4 leader produces no write
        pulse_start();
        send(8'o0); send(8'o200); send(8'o0);
        chk("R4 no write in leader", wr_cnt, 0);
        send_pair(1'b1, 12'o7776);
        send_pair(1'b0, 12'o0102);
        send_pair(1'b0, 12'o0304);
        send_pair(1'b0, 12'o0506);
        finish_load(tsum);
        chk("R3 wrap write count", wr_cnt, 3);
        chk("R3 first address", wr_addr[0], 15'o07776);
        chk("R3 second address", wr_addr[1], 15'o07777);
        chk("R3 wrapped address", wr_addr[2], 15'o00000);
        chk("R2 origin pair not written, data", wr_data[2], 12'o0506);
        stream_end = 1'b1; @(negedge clk); stream_end = 1'b0; @(negedge clk);
        chk("R10 stream end after done", fmt_err, 0);

        // R5 rubout discards itself and the next character
        pulse_start();
        send(8'o0);
        send_pair(1'b1, 12'o0400);
        send(8'o377); send(8'o101);
        send_pair(1'b0, 12'o1111);
        finish_load(tsum);
        chk("R5 rubout write count", wr_cnt, 1);
        chk("R5 rubout address", wr_addr[0], 15'o00400);
        chk("R5 rubout data", wr_data[0], 12'o1111);
        chk("R5 rubout not summed", csum_err, 0);

        // R6 field command applies one pair late
        pulse_start();
        send_pair(1'b1, 12'o0100);
        send_sum(8'o012);
        send(8'o310);
        send_sum(8'o034);
        send_pair(1'b0, 12'o4321);
        finish_load(tsum);
        chk("R6 late field count", wr_cnt, 2);
        chk("R6 pair in progress keeps old field", wr_addr[0], 15'o00100);
        chk("R6 next pair uses new field", wr_addr[1], 15'o10101);
        chk("R6 data", wr_data[1], 12'o4321);

        // R11 start clears origin, field and sum; R13 quiet after end
        pulse_start();
        chk("R11 start clears done", done, 0);
        send(8'o0);
        send_pair(1'b0, 12'o0707);
        finish_load(tsum);
        chk("R11 cleared address", wr_addr[0], 15'o00000);
        chk("R11 cleared sum", csum_err, 0);
        send(8'o01); send(8'o02); send(8'o03); send(8'o04);
        repeat (2) @(negedge clk);
        chk("R13 no write after end", wr_cnt, 1);
        chk("R13 done held", done, 1);

        // R7 checksum mismatch
        pulse_start();
        send_pair(1'b1, 12'o0000);
        send_pair(1'b0, 12'o0007);
        finish_load(tsum + 12'd1);
        chk("R7 bad checksum done", done, 1);
        chk("R7 bad checksum flag", csum_err, 1);

        // R8 boundary: last word of 4K memory is allowed
        mem_size = 16'd4096;
        pulse_start();
        send_pair(1'b1, 12'o7777);
        send_pair(1'b0, 12'o0555);
        finish_load(tsum);
        chk("R8 top word write", wr_cnt, 1);
        chk("R8 top word no error", addr_err, 0);

        // R8 beyond memory: field 1 with 4K words
        pulse_start();
        send(8'o0); send(8'o310);
        send_pair(1'b1, 12'o0000);
        send_pair(1'b0, 12'o0123);
        finish_load(tsum);
        chk("R8 address error", addr_err, 1);
        chk("R8 no write", wr_cnt, 0);
        chk("R8 not done", done, 0);
        send(8'o01); send(8'o02); send(8'o03);
        repeat (2) @(negedge clk);
        chk("R13 halted stays quiet", wr_cnt, 0);
        mem_size = 16'd32768;

        // R9 address/data mode
        fmt_sel = 1'b1;
        pulse_start();
        send(8'o0); send(8'o200); send(8'o0);
        send(8'o101); send(8'o023);
        send(8'o012); send(8'o034);
        send(8'o056); send(8'o070);
        send(8'o200);
        repeat (2) @(negedge clk);
        chk("R9 write count", wr_cnt, 2);
        chk("R9 first address", wr_addr[0], 15'o00123);
        chk("R9 no increment", wr_addr[1], 15'o00123);
        chk("R9 second data", wr_data[1], 12'o5670);
        chk("R9 done", done, 1);
        chk("R9 no checksum", csum_err, 0);
        fmt_sel = 1'b0;

        // R10 early end of stream
        pulse_start();
        send(8'o0);
        send_pair(1'b1, 12'o0005);
        stream_end = 1'b1; @(negedge clk); stream_end = 1'b0; @(negedge clk);
        chk("R10 format error", fmt_err, 1);
        chk("R10 not done", done, 0);
        pulse_start();
        chk("R11 start clears format error", fmt_err, 0);

        chk("R12 ready low on write, no back-to-back", viol, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule